// File: doc/BRIEF.md
# Double-Hash Nonce Search Engine

This block searches a contiguous range of 32-bit nonces for one whose double SHA-256 value, taken over an 80-byte block header, is numerically below a 256-bit target. The caller does not send the whole header. It sends a chaining value that already covers the leading 64 header bytes, plus the 12 trailing header bytes that do not include the nonce. For each candidate nonce the block compresses one padded tail block from that chaining value. It then hashes the resulting 32-byte digest again from the standard initial values and compares the final value with the target.

A job is loaded with a one-cycle strobe. The strobe carries the chaining value, the tail bytes, the first and last nonce, the target and a job tag. A single compression engine runs one round per clock. A trial takes 131 cycles: one load cycle, 64 rounds, a second load cycle, 64 more rounds and one compare cycle. Each hit is presented on a valid/ready output together with the tag of the job that produced it. When the output is occupied, the search waits rather than dropping a hit. Loading a new job at any time abandons the current search.

Top module: `nonce_searcher`

## Requirements
- R1: The first compression starts from `jobMidstate` (word H0 in bits 255:224, H7 in bits 31:0). It compresses a block whose words W0..W2 are `jobTail[95:64]`, `jobTail[63:32]` and `jobTail[31:0]`, W3 is the nonce as a plain 32-bit word, W4 is 0x80000000, W5..W14 are zero and W15 is 640.
- R2: The second compression starts from the standard SHA-256 initial values. It compresses a block whose words W0..W7 are the first digest (each word is chaining word plus working word), W8 is 0x80000000, W9..W14 are zero and W15 is 256.
- R3: The final digest is read as a 256-bit unsigned number, with H0 as the most significant word. A nonce is a hit only when this number is strictly less than `jobTarget` (same word order). Equality is not a hit.
- R4: Every nonce from `jobStart` to `jobEnd` inclusive is tried exactly once, in increasing order. Hits leave in that same order.
- R5: When `jobStart` is greater than `jobEnd`, the walk continues past 0xFFFFFFFF to 0 and stops after `jobEnd`.
- R6: Every hit shows the nonce on `hitNonce` and the tag given with its job on `hitJob`.
- R7: While `hitValid` is high and `hitReady` is low, the hit outputs hold steady. A further hit pauses the search, and no hit is lost.
- R8: A `jobLoad` pulse abandons any search in progress, clears `done`, and raises `busy` on the next cycle. All later hits belong to the new job, starting from its first nonce.
- R9: `done` rises only after the last nonce of the range has been tried. It is never high together with `busy`, and it stays high until the next `jobLoad`.
- R10: After reset the block is idle: `busy`, `done` and `hitValid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| jobLoad | input | 1 | One-cycle strobe that captures all job fields |
| jobMidstate | input | 256 | Chaining value after the first 64 header bytes |
| jobTail | input | 96 | The 12 header bytes that follow, without the nonce |
| jobStart | input | 32 | First nonce to try |
| jobEnd | input | 32 | Last nonce to try |
| jobTarget | input | 256 | Threshold; a hit is strictly below it |
| jobId | input | JOB_W | Tag returned with each hit |
| busy | output | 1 | A search is in progress or paused |
| done | output | 1 | The whole range has been tried |
| hitValid | output | 1 | A hit is presented |
| hitReady | input | 1 | Consumer accepts the presented hit |
| hitNonce | output | 32 | Nonce of the presented hit |
| hitJob | output | JOB_W | Tag of the job that produced the hit |

## Verification
The assertions check the handshake and flag relations on every cycle. They cover held hit outputs during a stall, `busy` and `done` never being high together, `done` rising only out of an active search, and a load always restarting the search. Whether the hash arithmetic, the padding words, the strict compare, the visiting order, the wrap past 0xFFFFFFFF and the loss-free pause are correct can only be seen in the bench scenarios. There, each collected hit list is compared with a list computed by an independent software model of SHA-256.

// File: rtl/nsrch_pkg.sv
package nsrch_pkg;

  localparam int NONCE_W = 32;
  localparam int ROUNDS  = 64;
  localparam int RND_W   = $clog2(ROUNDS);
  localparam int HASH_W  = 256;
  localparam int TAIL_W  = 96;

  // Round constants of SHA-256
  localparam logic [31:0] K_TAB [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam logic [31:0] IV_TAB [8] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureJob;
    logic loadFirst;
    logic loadSecond;
    logic doRound;
  } ctlStrobes_t;

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] sumBig0(input logic [31:0] x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic logic [31:0] sumBig1(input logic [31:0] x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic logic [31:0] sumSmall0(input logic [31:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sumSmall1(input logic [31:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

endpackage

// File: rtl/nsrch_datapath.sv
module nsrch_datapath
  import nsrch_pkg::*;
#(
  parameter int JOB_W = 8
) (
  input  logic                clk,
  input  ctlStrobes_t         ctl,
  input  logic [RND_W-1:0]    rnd,
  input  logic [NONCE_W-1:0]  nonce,
  input  logic [HASH_W-1:0]   jobMidstate,
  input  logic [TAIL_W-1:0]   jobTail,
  input  logic [HASH_W-1:0]   jobTarget,
  input  logic [JOB_W-1:0]    jobId,
  output logic                isHit,
  output logic [JOB_W-1:0]    jobIdQ
);

  localparam int WORDS = 16;
  localparam int TAIL_WORDS = TAIL_W / 32;

  logic [HASH_W-1:0] midQ;
  logic [TAIL_W-1:0] tailQ;
  logic [HASH_W-1:0] targetQ;

  logic [31:0] st [8];       // working variables a..h
  logic [31:0] w  [WORDS];   // rolling message schedule
  logic [31:0] blkFirst  [WORDS];
  logic [31:0] blkSecond [WORDS];
  logic [31:0] digestOne [8];
  logic [HASH_W-1:0] digestTwo;
  logic [31:0] wNext, t1, t2;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      digestOne[i] = midQ[HASH_W-1-32*i -: 32] + st[i];
      digestTwo[HASH_W-1-32*i -: 32] = IV_TAB[i] + st[i];
    end
    for (int i = 0; i < WORDS; i++) begin
      blkFirst[i]  = '0;
      blkSecond[i] = '0;
    end
    for (int i = 0; i < TAIL_WORDS; i++)
      blkFirst[i] = tailQ[TAIL_W-1-32*i -: 32];
    blkFirst[TAIL_WORDS]     = nonce;
    blkFirst[TAIL_WORDS + 1] = 32'h8000_0000;
    blkFirst[WORDS-1]        = 32'd640;
    for (int i = 0; i < 8; i++)
      blkSecond[i] = digestOne[i];
    blkSecond[8]       = 32'h8000_0000;
    blkSecond[WORDS-1] = 32'd256;

    wNext = sumSmall1(w[14]) + w[9] + sumSmall0(w[1]) + w[0];
    t1 = st[7] + sumBig1(st[4]) + ((st[4] & st[5]) ^ (~st[4] & st[6])) + K_TAB[rnd] + w[0];
    t2 = sumBig0(st[0]) + ((st[0] & st[1]) ^ (st[0] & st[2]) ^ (st[1] & st[2]));
  end

  assign isHit = digestTwo < targetQ;

  always_ff @(posedge clk) begin
    if (ctl.captureJob) begin
      midQ    <= jobMidstate;
      tailQ   <= jobTail;
      targetQ <= jobTarget;
      jobIdQ  <= jobId;
    end
    if (ctl.loadFirst) begin
      for (int i = 0; i < 8; i++) st[i] <= midQ[HASH_W-1-32*i -: 32];
      for (int i = 0; i < WORDS; i++) w[i] <= blkFirst[i];
    end else if (ctl.loadSecond) begin
      for (int i = 0; i < 8; i++) st[i] <= IV_TAB[i];
      for (int i = 0; i < WORDS; i++) w[i] <= blkSecond[i];
    end else if (ctl.doRound) begin
      st[0] <= t1 + t2;
      st[1] <= st[0];
      st[2] <= st[1];
      st[3] <= st[2];
      st[4] <= st[3] + t1;
      st[5] <= st[4];
      st[6] <= st[5];
      st[7] <= st[6];
      for (int i = 0; i < WORDS-1; i++) w[i] <= w[i+1];
      w[WORDS-1] <= wNext;
    end
  end

endmodule

// File: rtl/nsrch_control.sv
module nsrch_control
  import nsrch_pkg::*;
#(
  parameter int JOB_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                jobLoad,
  input  logic [NONCE_W-1:0]  jobStart,
  input  logic [NONCE_W-1:0]  jobEnd,
  input  logic                isHit,
  input  logic [JOB_W-1:0]    jobIdQ,
  input  logic                hitReady,
  output ctlStrobes_t         ctl,
  output logic [RND_W-1:0]    rnd,
  output logic [NONCE_W-1:0]  nonce,
  output logic                busy,
  output logic                done,
  output logic                hitValid,
  output logic [NONCE_W-1:0]  hitNonce,
  output logic [JOB_W-1:0]    hitJob
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD1, S_RUN1, S_LOAD2, S_RUN2, S_CMP} state_t;

  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  state_t state;
  logic [NONCE_W-1:0] endQ;
  logic slotFree;

  assign slotFree = !hitValid || hitReady;
  assign busy     = (state != S_IDLE);

  always_comb begin
    ctl.captureJob = jobLoad;
    ctl.loadFirst  = (state == S_LOAD1);
    ctl.loadSecond = (state == S_LOAD2);
    ctl.doRound    = (state == S_RUN1) || (state == S_RUN2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rnd      <= '0;
      nonce    <= '0;
      endQ     <= '0;
      done     <= 1'b0;
      hitValid <= 1'b0;
      hitNonce <= '0;
      hitJob   <= '0;
    end else begin
      if (hitReady) hitValid <= 1'b0;
      if (jobLoad) begin
        state <= S_LOAD1;
        nonce <= jobStart;
        endQ  <= jobEnd;
        done  <= 1'b0;
      end else begin
        case (state)
          S_LOAD1: begin rnd <= '0; state <= S_RUN1; end
          S_RUN1: begin
            rnd <= rnd + 1'b1;
            if (rnd == LAST_RND) state <= S_LOAD2;
          end
          S_LOAD2: begin rnd <= '0; state <= S_RUN2; end
          S_RUN2: begin
            rnd <= rnd + 1'b1;
            if (rnd == LAST_RND) state <= S_CMP;
          end
          S_CMP: begin
            if (!isHit || slotFree) begin
              if (isHit) begin
                hitValid <= 1'b1;
                hitNonce <= nonce;
                hitJob   <= jobIdQ;
              end
              if (nonce == endQ) begin
                state <= S_IDLE;
                done  <= 1'b1;
              end else begin
                nonce <= nonce + 1'b1;
                state <= S_LOAD1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/nonce_searcher.sv
module nonce_searcher
  import nsrch_pkg::*;
#(
  parameter int JOB_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               jobLoad,
  input  logic [255:0]       jobMidstate,
  input  logic [95:0]        jobTail,
  input  logic [31:0]        jobStart,
  input  logic [31:0]        jobEnd,
  input  logic [255:0]       jobTarget,
  input  logic [JOB_W-1:0]   jobId,
  output logic               busy,
  output logic               done,
  output logic               hitValid,
  input  logic               hitReady,
  output logic [31:0]        hitNonce,
  output logic [JOB_W-1:0]   hitJob
);

  ctlStrobes_t ctl;
  logic [RND_W-1:0] rnd;
  logic [NONCE_W-1:0] nonce;
  logic isHit;
  logic [JOB_W-1:0] jobIdQ;

  nsrch_control #(.JOB_W(JOB_W)) u_ctl (
    .clk(clk), .rstN(rstN), .jobLoad(jobLoad), .jobStart(jobStart), .jobEnd(jobEnd),
    .isHit(isHit), .jobIdQ(jobIdQ), .hitReady(hitReady), .ctl(ctl), .rnd(rnd),
    .nonce(nonce), .busy(busy), .done(done), .hitValid(hitValid),
    .hitNonce(hitNonce), .hitJob(hitJob)
  );

  nsrch_datapath #(.JOB_W(JOB_W)) u_dp (
    .clk(clk), .ctl(ctl), .rnd(rnd), .nonce(nonce), .jobMidstate(jobMidstate),
    .jobTail(jobTail), .jobTarget(jobTarget), .jobId(jobId),
    .isHit(isHit), .jobIdQ(jobIdQ)
  );

endmodule

// File: rtl/searcher_checker.sv
module searcher_checker #(
  parameter int JOB_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             jobLoad,
  input logic             busy,
  input logic             done,
  input logic             hitValid,
  input logic             hitReady,
  input logic [31:0]      hitNonce,
  input logic [JOB_W-1:0] hitJob
);

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && !hitReady) |=> (hitValid && $stable(hitNonce) && $stable(hitJob)));

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  a_r9_done_from_search: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  a_r8_load_restarts: assert property (@(posedge clk) disable iff (!rstN)
    jobLoad |=> (busy && !done));

  a_r6_hit_from_search: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitValid) |-> $past(busy));

endmodule

bind nonce_searcher searcher_checker #(.JOB_W(JOB_W)) u_chk (
  .clk(clk), .rstN(rstN), .jobLoad(jobLoad), .busy(busy), .done(done),
  .hitValid(hitValid), .hitReady(hitReady), .hitNonce(hitNonce), .hitJob(hitJob)
);

// File: tb/sim_nonce_searcher.sv
`timescale 1ns/1ps
module sim_nonce_searcher;
  import nsrch_pkg::K_TAB;

  localparam int JOB_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic jobLoad = 1'b0;
  logic [255:0] jobMidstate = '0;
  logic [95:0] jobTail = '0;
  logic [31:0] jobStart = '0, jobEnd = '0;
  logic [255:0] jobTarget = '0;
  logic [JOB_W-1:0] jobId = '0;
  logic busy, done, hitValid, hitReady = 1'b1;
  logic [31:0] hitNonce;
  logic [JOB_W-1:0] hitJob;

  int checks = 0;
  int fails = 0;
  logic [31:0] gotN[$];
  logic [JOB_W-1:0] gotJ[$];
  logic [31:0] expN[$];

  localparam logic [255:0] SHA_IV =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

  always #2 clk = ~clk;

  nonce_searcher #(.JOB_W(JOB_W)) u0 (
    .clk(clk), .rstN(rstN), .jobLoad(jobLoad), .jobMidstate(jobMidstate), .jobTail(jobTail),
    .jobStart(jobStart), .jobEnd(jobEnd), .jobTarget(jobTarget), .jobId(jobId),
    .busy(busy), .done(done), .hitValid(hitValid), .hitReady(hitReady),
    .hitNonce(hitNonce), .hitJob(hitJob)
  );

  // hit collector: transfers happen at the rising edge
  always @(posedge clk) begin
    if (rstN && hitValid && hitReady) begin
      gotN.push_back(hitNonce);
      gotJ.push_back(hitJob);
    end
  end

  function automatic logic [31:0] bRot(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] bCompress(input logic [255:0] hIn, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    logic [255:0] res;
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 64; i++)
      w[i] = (bRot(w[i-2], 17) ^ bRot(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
           + (bRot(w[i-15], 7) ^ bRot(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
    for (int i = 0; i < 8; i++) v[i] = hIn[255-32*i -: 32];
    for (int i = 0; i < 64; i++) begin
      t1 = v[7] + (bRot(v[4], 6) ^ bRot(v[4], 11) ^ bRot(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + K_TAB[i] + w[i];
      t2 = (bRot(v[0], 2) ^ bRot(v[0], 13) ^ bRot(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) res[255-32*i -: 32] = hIn[255-32*i -: 32] + v[i];
    return res;
  endfunction

  function automatic logic [255:0] trialHash(input logic [255:0] mid, input logic [95:0] tail,
                                             input logic [31:0] n);
    logic [255:0] d1;
    d1 = bCompress(mid, {tail, n, 32'h8000_0000, 320'b0, 32'd640});
    return bCompress(SHA_IV, {d1, 32'h8000_0000, 192'b0, 32'd256});
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic loadJob(input logic [255:0] mid, input logic [95:0] tail, input logic [31:0] s,
                         input logic [31:0] e, input logic [255:0] tgt, input logic [JOB_W-1:0] id);
    @(negedge clk);
    jobMidstate = mid; jobTail = tail; jobStart = s; jobEnd = e; jobTarget = tgt; jobId = id;
    jobLoad = 1'b1;
    @(negedge clk);
    jobLoad = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int cnt = 0;
    while (!done && cnt < 4000) begin @(negedge clk); cnt++; end
    check(done === 1'b1, req, "done after range", {255'b0, done}, 256'd1);
    repeat (3) @(negedge clk);
  endtask

  // model of the hit list (R3, R4, R5)
  task automatic buildExpected(input logic [255:0] mid, input logic [95:0] tail,
                               input logic [31:0] s, input logic [31:0] e, input logic [255:0] tgt);
    logic [31:0] n = s;
    expN.delete();
    forever begin
      if (trialHash(mid, tail, n) < tgt) expN.push_back(n);
      if (n == e) break;
      n = n + 1;
    end
  endtask

  task automatic compareHits(input string req, input logic [JOB_W-1:0] id);
    check(gotN.size() == expN.size(), req, "hit count", 256'(gotN.size()), 256'(expN.size()));
    for (int i = 0; i < expN.size() && i < gotN.size(); i++) begin
      check(gotN[i] === expN[i], req, "hit nonce", 256'(gotN[i]), 256'(expN[i]));
      check(gotJ[i] === id, "R6", "hit job tag", 256'(gotJ[i]), 256'(id));
    end
  endtask

  task automatic runJob(input string req, input logic [255:0] mid, input logic [95:0] tail,
                        input logic [31:0] s, input logic [31:0] e, input logic [255:0] tgt,
                        input logic [JOB_W-1:0] id);
    buildExpected(mid, tail, s, e, tgt);
    gotN.delete(); gotJ.delete();
    loadJob(mid, tail, s, e, tgt, id);
    waitDone(req);
    compareHits(req, id);
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(4 * 190000);
    check(1'b0, "ALL", "watchdog expired", 256'd0, 256'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] mid, hv;
    logic [95:0] tail;
    logic [31:0] s;
    void'($urandom(32'd1234));

    // bench model sanity: one-block hash of "abc"
    check(bCompress(SHA_IV, {32'h61626380, 448'b0, 32'h18}) ===
          256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad,
          "R2", "model sanity", bCompress(SHA_IV, {32'h61626380, 448'b0, 32'h18}), 256'd0);

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, hitValid} === 3'b000, "R10", "reset state", 256'({busy, done, hitValid}), 256'd0);

    mid = rnd256(); tail = {$urandom, $urandom, $urandom};

    // every nonce hits with an all-ones target (R1, R2, R4)
    runJob("R4", mid, tail, 32'd50, 32'd53, {256{1'b1}}, 8'h11);
    // zero target never hits
    runJob("R3", mid, tail, 32'd7, 32'd9, 256'd0, 8'h12);
    // equality is not a hit, one above is
    hv = trialHash(mid, tail, 32'd20);
    runJob("R3", mid, tail, 32'd20, 32'd20, hv, 8'h13);
    runJob("R3", mid, tail, 32'd20, 32'd20, hv + 1, 8'h14);
    // wrap past the top of the nonce space
    runJob("R5", mid, tail, 32'hFFFF_FFFE, 32'd1, {256{1'b1}}, 8'h15);
    check(expN.size() == 4, "R5", "wrap model length", 256'(expN.size()), 256'd4);

    // random jobs with a target placed at one trial's hash
    for (int it = 0; it < 14; it++) begin
      int len, k;
      mid = rnd256(); tail = {$urandom, $urandom, $urandom};
      len = 1 + ($urandom % 5); k = $urandom % len;
      s = $urandom;
      hv = trialHash(mid, tail, s + 32'(k));
      runJob("R1", mid, tail, s, s + 32'(len - 1), hv + 256'($urandom % 2), 8'(it));
    end

    // stall: output held, search paused, nothing lost (R7)
    mid = rnd256();
    buildExpected(mid, tail, 32'd10, 32'd12, {256{1'b1}});
    gotN.delete(); gotJ.delete();
    @(negedge clk); hitReady = 1'b0;
    loadJob(mid, tail, 32'd10, 32'd12, {256{1'b1}}, 8'h77);
    repeat (600) @(negedge clk);
    check(hitValid === 1'b1 && hitNonce === 32'd10, "R7", "held first hit", 256'(hitNonce), 256'd10);
    check(busy === 1'b1 && done === 1'b0, "R7", "paused not done", 256'({busy, done}), 256'b10);
    hitReady = 1'b1;
    waitDone("R7");
    compareHits("R7", 8'h77);

    // abort a long search with a new job (R8)
    gotN.delete(); gotJ.delete();
    loadJob(mid, tail, 32'd100, 32'd400, 256'd0, 8'h21);
    repeat (300) @(negedge clk);
    check(busy === 1'b1, "R8", "first job running", 256'(busy), 256'd1);
    buildExpected(mid, tail, 32'd5, 32'd6, {256{1'b1}});
    loadJob(mid, tail, 32'd5, 32'd6, {256{1'b1}}, 8'h22);
    check(done === 1'b0 && busy === 1'b1, "R8", "restart flags", 256'({busy, done}), 256'b10);
    waitDone("R8");
    compareHits("R8", 8'h22);
    check(busy === 1'b0 && done === 1'b1, "R9", "done holds idle", 256'({busy, done}), 256'b01);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule